// File: doc/BRIEF.md
# Isolated-Zero Gap Filter for a Serial Bit Stream

This block cleans a one-bit serial stream by filling single-sample dropouts. A lone 0 with a 1 on each side of it is replaced by a 1. A run of two or more 0s is left as it is. The block keeps the three most recent samples in a short window register and drives its output from the oldest one. Each sample therefore leaves the block three clock edges after it entered.

The fill rule is not a vote across the window. When a 1 arrives while the middle sample of the window is 1, the whole window is loaded with ones. In that case the newest slot and the oldest slot would both hold 1 after the edge anyway. The only real effect is that a 0 waiting in the second slot becomes 1 before it shifts to the output. A synchronous reset, sampled on the rising edge, empties the window.

Top module: `binary_gap_filter`

## Requirements
- R1: While `srst` is 1 at a rising edge, all three window stages become 0, and `bit_out` is 0 after that edge.
- R2: When neither reset nor the fill condition holds, the window shifts on each edge. The newest stage takes `bit_in`, the middle stage takes the newest, and the oldest stage takes the middle.
- R3: When `bit_in` is 1 and the middle stage is 1 at an edge, without reset, all three stages become 1.
- R4: `bit_out` is the oldest stage. An input 1 sampled at edge n is seen on `bit_out` after edge n+2, so the latency is three edges counting the sampling edge.
- R5: Reset wins over the fill condition. With `srst`=1, `bit_in`=1 and the middle stage 1, the window still clears to 000.
- R6: An input pattern 1,0,1 never shows its 0 at `bit_out`; the output carries 1 in that slot.
- R7: Zero runs of length two or more reach `bit_out` unchanged, in order, delayed by the latency of R4.
- R8: After reset, `bit_out` stays 0 until an input 1 has passed through all three stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial sample in |
| bit_out | output | 1 | Filtered serial sample out |

## Verification
The assertions assume that `bit_in` and `srst` are settled, known values at every rising edge, and that reset is held from time zero through the first edge. The latency and no-lone-gap properties also assume that the window has been filled since the last reset. The assertions check this with their own count of cycles since reset. The bench asserts reset before the first edge, and it changes inputs only on the falling edge. It also leaves at least three clean edges after each reset before it depends on the history from before that reset.

// File: rtl/gap_filter_pkg.sv
package gap_filter_pkg;

  localparam int WINDOW = 3;
  localparam int NEW_IDX = 0;
  localparam int MID_IDX = 1;
  localparam int OLD_IDX = WINDOW - 1;

  typedef logic [WINDOW-1:0] window_t;

  // Fill is needed when a fresh 1 lands while the middle slot holds 1.
  function automatic logic gap_fill(input logic fresh, input window_t win);
    return fresh & win[MID_IDX];
  endfunction

  // Next window content for the non-reset case.
  function automatic window_t window_next(input logic fresh, input logic fill,
                                          input window_t win);
    window_t nxt;
    if (fill) nxt = '1;
    else      nxt = {win[WINDOW-2:0], fresh};
    return nxt;
  endfunction

endpackage

// File: rtl/gf_gap_detect.sv
module gf_gap_detect
  import gap_filter_pkg::*;
(
  input  logic    fresh,
  input  window_t win,
  output logic    fill
);

  always_comb fill = gap_fill(fresh, win);

endmodule

// File: rtl/gf_window_reg.sv
module gf_window_reg
  import gap_filter_pkg::*;
(
  input  logic    clk,
  input  logic    srst,
  input  logic    fresh,
  input  logic    fill,
  output window_t win
);

  always_ff @(posedge clk) begin
    if (srst) win <= '0;
    else      win <= window_next(fresh, fill, win);
  end

  assert_clear_R1: assert property (@(posedge clk) srst |=> (win == '0));

  assert_fill_R3: assert property (@(posedge clk) disable iff (srst)
    fill |=> (win == '1));

  assert_shift_R2: assert property (@(posedge clk) disable iff (srst)
    !fill |=> (win[NEW_IDX] == $past(fresh)) &&
              (win[MID_IDX] == $past(win[NEW_IDX])) &&
              (win[OLD_IDX] == $past(win[MID_IDX])));

  assert_reset_wins_R5: assert property (@(posedge clk)
    (srst && fill) |=> (win == '0));

endmodule

// File: rtl/binary_gap_filter.sv
module binary_gap_filter
  import gap_filter_pkg::*;
(
  input  logic clk,
  input  logic srst,
  input  logic bit_in,
  output logic bit_out
);

  window_t win;
  logic    fill_evt;
  logic [1:0] since_rst;

  gf_gap_detect u_detect (
    .fresh (bit_in),
    .win   (win),
    .fill  (fill_evt)
  );

  gf_window_reg u_window (
    .clk   (clk),
    .srst  (srst),
    .fresh (bit_in),
    .fill  (fill_evt),
    .win   (win)
  );

  assign bit_out = win[OLD_IDX];

  // Cycles since reset, saturating; guards properties that look back.
  always_ff @(posedge clk) begin
    if (srst)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (srst)
    (since_rst == 2'd3 && $past(bit_in, 3)) |-> bit_out);

  assert_no_lone_gap_R6: assert property (@(posedge clk) disable iff (srst)
    (since_rst == 2'd3 && $fell(bit_out)) |=> !bit_out);

  assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (srst)
    (since_rst != 2'd3) |-> !bit_out);

endmodule

// File: tb/binary_gap_filter_bench.sv
module binary_gap_filter_bench;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [3:0] hist = '0; // hist[0] = latest sample, hist[3] = oldest

  always #4 clk = ~clk;

  binary_gap_filter u_binary_gap_filter (
    .clk(clk), .srst(srst), .bit_in(bit_in), .bit_out(bit_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: bit_out=%b expected=%b", tag, act, exp);
    end
  endtask

  // One edge; the expected output is the sample from two edges back,
  // lifted to 1 if both of its neighbours were 1.
  task automatic step(input logic r, input logic d, input string tag);
    logic exp;
    @(negedge clk);
    srst = r;
    bit_in = d;
    @(posedge clk);
    #1;
    if (r) hist = '0;
    else   hist = {hist[2:0], d};
    exp = r ? 1'b0 : (hist[2] | (hist[3] & hist[1]));
    check(bit_out, exp, tag);
  endtask

  task automatic feed(input logic [31:0] pat, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(1'b0, pat[i], tag);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, "R1 reset");
    step(1'b1, 1'b0, "R1 reset");
  endtask

  task automatic t_latency;
    step(1'b0, 1'b1, "R8 quiet");
    step(1'b0, 1'b0, "R8 quiet");
    step(1'b0, 1'b0, "R4 latency");
    feed(32'b000, 3, "R2 shift");
  endtask

  task automatic t_lone_gap;
    feed(32'b1_0_1_0_0_0, 6, "R6 lone gap");
    feed(32'b1_1_0_1_1_0_0_0, 8, "R3 fill");
  endtask

  task automatic t_wide_gaps;
    feed(32'b1_0_0_1_0_0_0_1_1_0_0_0, 12, "R7 zero run");
  endtask

  task automatic t_alternating;
    feed(32'b1_0_1_0_1_0_1_0_0_0, 10, "R6 alternating");
    feed(32'b1_1_1_0_0_1_0_1_1_0_0_0, 12, "R2 mixed");
  endtask

  task automatic t_reset_priority;
    feed(32'b11, 2, "R3 prime");
    step(1'b1, 1'b1, "R5 reset over fill");
    step(1'b0, 1'b0, "R5 after");
    step(1'b0, 1'b0, "R5 after");
    step(1'b0, 1'b0, "R5 after");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_lone_gap();
    t_wide_gaps();
    t_alternating();
    t_reset_priority();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule